// File: doc/BRIEF.md
# Trellis Survivor-Selection Stage

This block carries out one stage of a sort-free tree search for a soft MIMO detector. The search trellis has Q vertices per stage, one for each constellation point. The block keeps exactly one survivor per vertex. A K-best search would sort all candidates; this block instead runs an independent running minimum in each of Q parallel vertex lanes. Each lane walks serially over its Q candidates and keeps the cheapest one. A stage therefore takes Q cycles plus two pipeline cycles.

A mode input selects one of two pruning rules over the same datapath. In pruning of incoming edges (reduction, mode 0), lane q looks at every source path k and keeps the best predecessor of vertex q. In pruning of outgoing edges (extension, mode 1), lane k looks at every next symbol q for its own surviving path and keeps the best continuation. Each candidate cost is the stored partial distance plus an approximate edge weight. The weight is the L1 norm of the residual y − δ_k − R·s_q, where δ_k is the interference term of path k. The per-path interference terms can be kept from the previous stage, so an extension feeding a reduction does not have to reload them.

The control machine has four states: ST_IDLE, ST_SCAN, ST_FLUSH and ST_DONE. The transitions are:
- ST_IDLE to ST_SCAN when start is seen (this is the accept).
- ST_SCAN stays in ST_SCAN while the candidate counter is below Q−1, and moves to ST_FLUSH when the counter reaches Q−1.
- ST_FLUSH moves unconditionally to ST_DONE.
- ST_DONE moves unconditionally back to ST_IDLE.

Top module: `trellis_stage_unit`

## Requirements
- R1: After reset, done is low and every lane of dist_out and idx_out reads zero.
- R2: With mode=0 (reduction), lane q outputs the minimum over sources k of cost(k,q), where cost(k,q) uses dist_in[k], delta[k] and symbol q. idx_out lane q holds the k that gave the minimum.
- R3: With mode=1 (extension), lane k outputs the minimum over symbols q of cost(k,q). idx_out lane k holds the q that gave the minimum.
- R4: cost(k,q) = d_k + |Re e| + |Im e|, where e = y − δ_k − R·s_q and R·s_q is a full complex product. The symbol index is split into two halves. The upper IW/2 bits give the real level index i, and the lower IW/2 bits give the imaginary level index. A level is 2i−(S−1), with S = √Q. For Q=4 this gives 0:−1−j, 1:−1+j, 2:1−j, 3:1+j.
- R5: When candidates tie on cost, the lowest candidate index is kept.
- R6: Each candidate cost saturates at 2^PW−1.
- R7: done is high for exactly one cycle, and it appears Q+1 rising edges after the edge that accepted start.
- R8: All operands and the mode are captured at the accepting edge. A start seen in ST_SCAN, ST_FLUSH or ST_DONE is ignored, and input changes during a stage have no effect on its results.
- R9: A start with keep_delta=1 leaves the stored per-path interference terms unchanged, so the delta_re and delta_im inputs are ignored for that stage.
- R10: dist_out and idx_out keep their values from done until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a stage; honoured only in ST_IDLE |
| mode | input | 1 | 0 = reduction, 1 = extension |
| keep_delta | input | 1 | Retain the stored per-path interference terms |
| y_re | input | DW | Received sample, real part (signed) |
| y_im | input | DW | Received sample, imaginary part (signed) |
| rd_re | input | DW | Diagonal channel coefficient, real part (signed) |
| rd_im | input | DW | Diagonal channel coefficient, imaginary part (signed) |
| dist_in | input | Q*PW | Survivor partial distances, lane k at bits k*PW |
| delta_re | input | Q*DW | Per-path interference term, real part (signed lanes) |
| delta_im | input | Q*DW | Per-path interference term, imaginary part (signed lanes) |
| dist_out | output | Q*PW | Updated partial distances |
| idx_out | output | Q*log2(Q) | Chosen predecessor (mode 0) or successor symbol (mode 1) |
| done | output | 1 | One-cycle end-of-stage pulse |

## Verification
Two rules can decide the same compare. The saturation clamp can force several candidates to the ceiling, and the tie rule must then pick among equal clamped costs. The bench provokes this by loading large partial distances with a large diagonal coefficient. It then checks that the saturated lanes report 2^PW−1 with index zero, while a lane with one small distance still finds its unsaturated path. A second overlap arises when a new start coincides with a stage still in flight, or with its done cycle. The bench judges this by the latency, the single done pulse and unchanged results.

// File: rtl/tsu_pkg.sv
package tsu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_FLUSH = 2'd2,
        ST_DONE  = 2'd3
    } tsu_state_t;

    localparam logic MODE_REDUCE = 1'b0;
    localparam logic MODE_EXTEND = 1'b1;

endpackage

// File: rtl/tsu_ctrl.sv
module tsu_ctrl
    import tsu_pkg::*;
#(
    parameter int Q = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    output tsu_state_t            state,
    output logic                  accept,
    output logic                  scan_en,
    output logic                  done,
    output logic [$clog2(Q)-1:0]  cnt
);
    localparam int IW = $clog2(Q);
    localparam logic [IW-1:0] LAST = IW'(Q - 1);

    tsu_state_t state_q, state_d;
    logic [IW-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        scan_en = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    accept  = 1'b1;
                    state_d = ST_SCAN;
                end
            end
            ST_SCAN: begin
                scan_en = 1'b1;
                if (cnt_q == LAST) state_d = ST_FLUSH;
            end
            ST_FLUSH: state_d = ST_DONE;
            ST_DONE: begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // candidate counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (accept)  cnt_q <= '0;
        else if (scan_en) cnt_q <= cnt_q + 1'b1;
    end

    assign state = state_q;
    assign cnt   = cnt_q;
endmodule

// File: rtl/tsu_cost.sv
module tsu_cost #(
    parameter int Q  = 4,
    parameter int PW = 16,
    parameter int DW = 10
) (
    input  logic [PW-1:0]          d,
    input  logic signed [DW-1:0]   dre,
    input  logic signed [DW-1:0]   dim,
    input  logic signed [DW-1:0]   y_re,
    input  logic signed [DW-1:0]   y_im,
    input  logic signed [DW-1:0]   r_re,
    input  logic signed [DW-1:0]   r_im,
    input  logic [$clog2(Q)-1:0]   sym,
    output logic [PW-1:0]          cost
);
    localparam int IW  = $clog2(Q);
    localparam int HW  = IW / 2;
    localparam int S   = 1 << HW;
    localparam int LVW = HW + 2;
    localparam int RW  = DW + LVW + 3;
    localparam int CW  = ((PW > RW + 1) ? PW : RW + 1) + 1;
    localparam logic [PW-1:0] MAXD = {PW{1'b1}};

    logic signed [LVW-1:0] lv_re, lv_im;
    logic signed [RW-1:0]  e_re, e_im;
    logic [RW-1:0]         a_re, a_im;
    logic [RW:0]           w;
    logic [CW-1:0]         sum;

    always_comb begin
        lv_re = ($signed(LVW'(sym[IW-1:HW])) <<< 1) - $signed(LVW'(S - 1));
        lv_im = ($signed(LVW'(sym[HW-1:0])) <<< 1) - $signed(LVW'(S - 1));
        e_re  = RW'(y_re) - RW'(dre)
              - (RW'(r_re) * RW'(lv_re) - RW'(r_im) * RW'(lv_im));
        e_im  = RW'(y_im) - RW'(dim)
              - (RW'(r_re) * RW'(lv_im) + RW'(r_im) * RW'(lv_re));
        a_re  = e_re[RW-1] ? RW'(-e_re) : RW'(e_re);
        a_im  = e_im[RW-1] ? RW'(-e_im) : RW'(e_im);
        w     = (RW+1)'(a_re) + (RW+1)'(a_im);
        sum   = CW'(d) + CW'(w);
        cost  = (sum > CW'(MAXD)) ? MAXD : sum[PW-1:0];
    end
endmodule

// File: rtl/tsu_lane.sv
module tsu_lane #(
    parameter int Q  = 4,
    parameter int PW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cand_valid,
    input  logic                  cand_first,
    input  logic [PW-1:0]         cand_cost,
    input  logic [$clog2(Q)-1:0]  cand_idx,
    output logic [PW-1:0]         best_cost,
    output logic [$clog2(Q)-1:0]  best_idx
);
    localparam int IW = $clog2(Q);

    logic          p_valid, p_first;
    logic [PW-1:0] p_cost;
    logic [IW-1:0] p_idx;
    logic [PW-1:0] b_cost;
    logic [IW-1:0] b_idx;
    logic          take;

    // strict compare keeps the earlier (lower) index on a tie
    assign take = p_valid && (p_first || (p_cost < b_cost));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_valid <= 1'b0;
            p_first <= 1'b0;
            p_cost  <= '0;
            p_idx   <= '0;
            b_cost  <= '0;
            b_idx   <= '0;
        end else begin
            p_valid <= cand_valid;
            p_first <= cand_first;
            p_cost  <= cand_cost;
            p_idx   <= cand_idx;
            if (take) begin
                b_cost <= p_cost;
                b_idx  <= p_idx;
            end
        end
    end

    assign best_cost = b_cost;
    assign best_idx  = b_idx;
endmodule

// File: rtl/trellis_stage_unit.sv
module trellis_stage_unit
    import tsu_pkg::*;
#(
    parameter int Q  = 4,
    parameter int PW = 16,
    parameter int DW = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      mode,
    input  logic                      keep_delta,
    input  logic signed [DW-1:0]      y_re,
    input  logic signed [DW-1:0]      y_im,
    input  logic signed [DW-1:0]      rd_re,
    input  logic signed [DW-1:0]      rd_im,
    input  logic [Q*PW-1:0]           dist_in,
    input  logic [Q*DW-1:0]           delta_re,
    input  logic [Q*DW-1:0]           delta_im,
    output logic [Q*PW-1:0]           dist_out,
    output logic [Q*$clog2(Q)-1:0]    idx_out,
    output logic                      done
);
    localparam int IW = $clog2(Q);

    tsu_state_t         ctl_state;
    logic               accept, scan_en;
    logic [IW-1:0]      cnt;

    logic               mode_r;
    logic signed [DW-1:0] y_re_r, y_im_r, rd_re_r, rd_im_r;
    logic [Q*PW-1:0]    dist_bank;
    logic [Q*DW-1:0]    dre_bank, dim_bank;

    tsu_ctrl #(.Q(Q)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .state   (ctl_state),
        .accept  (accept),
        .scan_en (scan_en),
        .done    (done),
        .cnt     (cnt)
    );

    // operand capture at the accepting edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_r    <= MODE_REDUCE;
            y_re_r    <= '0;
            y_im_r    <= '0;
            rd_re_r   <= '0;
            rd_im_r   <= '0;
            dist_bank <= '0;
            dre_bank  <= '0;
            dim_bank  <= '0;
        end else if (accept) begin
            mode_r    <= mode;
            y_re_r    <= y_re;
            y_im_r    <= y_im;
            rd_re_r   <= rd_re;
            rd_im_r   <= rd_im;
            dist_bank <= dist_in;
            if (!keep_delta) begin
                dre_bank <= delta_re;
                dim_bank <= delta_im;
            end
        end
    end

    for (genvar l = 0; l < Q; l++) begin : g_lane
        logic [IW-1:0] src, sym;
        logic [PW-1:0] cost;
        logic [PW-1:0] best;
        logic [IW-1:0] bidx;

        always_comb begin
            if (mode_r == MODE_EXTEND) begin
                src = IW'(l);
                sym = cnt;
            end else begin
                src = cnt;
                sym = IW'(l);
            end
        end

        tsu_cost #(.Q(Q), .PW(PW), .DW(DW)) u_cost (
            .d    (dist_bank[src*PW +: PW]),
            .dre  (dre_bank[src*DW +: DW]),
            .dim  (dim_bank[src*DW +: DW]),
            .y_re (y_re_r),
            .y_im (y_im_r),
            .r_re (rd_re_r),
            .r_im (rd_im_r),
            .sym  (sym),
            .cost (cost)
        );

        tsu_lane #(.Q(Q), .PW(PW)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .cand_valid (scan_en),
            .cand_first (cnt == '0),
            .cand_cost  (cost),
            .cand_idx   (cnt),
            .best_cost  (best),
            .best_idx   (bidx)
        );

        assign dist_out[l*PW +: PW] = best;
        assign idx_out[l*IW +: IW]  = bidx;
    end
endmodule

// File: rtl/tsu_checker.sv
module tsu_checker
    import tsu_pkg::*;
#(
    parameter int Q  = 4,
    parameter int PW = 16,
    parameter int DW = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    keep_delta,
    input logic                    done,
    input tsu_state_t              state,
    input logic                    mode_r,
    input logic [Q*PW-1:0]         dist_out,
    input logic [Q*$clog2(Q)-1:0]  idx_out,
    input logic [Q*DW-1:0]         dre_bank,
    input logic [Q*DW-1:0]         dim_bank
);
    logic       acc;
    logic [7:0] since_q;

    assign acc = start && (state == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since_q <= '0;
        else if (acc)              since_q <= 8'd1;
        else if (since_q != '0 && since_q != 8'hFF) since_q <= since_q + 8'd1;
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (since_q == 8'(Q + 2)));

    // R10
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> ($stable(dist_out) && $stable(idx_out)));

    // R9
    keep_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && keep_delta) |=> ($stable(dre_bank) && $stable(dim_bank)));

    // R8
    busy_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(mode_r));
endmodule

bind trellis_stage_unit tsu_checker #(.Q(Q), .PW(PW), .DW(DW)) u_tsu_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .keep_delta (keep_delta),
    .done       (done),
    .state      (ctl_state),
    .mode_r     (mode_r),
    .dist_out   (dist_out),
    .idx_out    (idx_out),
    .dre_bank   (dre_bank),
    .dim_bank   (dim_bank)
);

// File: tb/trellis_stage_unit_bench.sv
`timescale 1ns/1ps
module trellis_stage_unit_bench;
    localparam int Q = 4, PW = 16, DW = 10, IW = 2, S = 2;
    localparam int MAXD = (1 << PW) - 1;

    logic clk = 1'b0;
    logic rst_n, start, mode, keep_delta, done;
    logic signed [DW-1:0] y_re, y_im, rd_re, rd_im;
    logic [Q*PW-1:0] dist_in, dist_out;
    logic [Q*DW-1:0] delta_re, delta_im;
    logic [Q*IW-1:0] idx_out;

    int n_tests = 0, n_fail = 0;
    int in_d[Q], in_dre[Q], in_dim[Q], st_dre[Q], st_dim[Q];
    int in_yre, in_yim, in_rre, in_rim;

    always #4 clk = ~clk;

    trellis_stage_unit #(.Q(Q), .PW(PW), .DW(DW)) u_trellis_stage_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .keep_delta(keep_delta),
        .y_re(y_re), .y_im(y_im), .rd_re(rd_re), .rd_im(rd_im),
        .dist_in(dist_in), .delta_re(delta_re), .delta_im(delta_im),
        .dist_out(dist_out), .idx_out(idx_out), .done(done));

    function automatic int lvl(int i);
        return 2 * i - (S - 1);
    endfunction

    function automatic int absi(int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int cost_of(int k, int q);
        int sr, si, er, ei, c;
        sr = lvl(q / S);
        si = lvl(q % S);
        er = in_yre - st_dre[k] - (in_rre * sr - in_rim * si);
        ei = in_yim - st_dim[k] - (in_rre * si + in_rim * sr);
        c  = in_d[k] + absi(er) + absi(ei);
        return (c > MAXD) ? MAXD : c;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_lanes(bit m, string tag);
        int bc, bi, c;
        for (int l = 0; l < Q; l++) begin
            bc = m ? cost_of(l, 0) : cost_of(0, l);
            bi = 0;
            for (int j = 1; j < Q; j++) begin
                c = m ? cost_of(l, j) : cost_of(j, l);
                if (c < bc) begin bc = c; bi = j; end
            end
            chk(tag, $sformatf("dist lane %0d", l), int'(dist_out[l*PW +: PW]), bc);
            chk(tag, $sformatf("idx lane %0d", l), int'(idx_out[l*IW +: IW]), bi);
        end
    endtask

    task automatic pack_ports();
        for (int k = 0; k < Q; k++) begin
            dist_in[k*PW +: PW]  = PW'(in_d[k]);
            delta_re[k*DW +: DW] = DW'(in_dre[k]);
            delta_im[k*DW +: DW] = DW'(in_dim[k]);
        end
        y_re = DW'(in_yre); y_im = DW'(in_yim);
        rd_re = DW'(in_rre); rd_im = DW'(in_rim);
    endtask

    function automatic int rs();
        return int'($urandom_range(0, 1023)) - 512;
    endfunction

    task automatic rand_inputs(int dmax);
        for (int k = 0; k < Q; k++) begin
            in_d[k] = int'($urandom_range(0, dmax));
            in_dre[k] = rs(); in_dim[k] = rs();
        end
        in_yre = rs(); in_yim = rs(); in_rre = rs(); in_rim = rs();
    endtask

    task automatic scramble_ports();
        for (int k = 0; k < Q; k++) begin
            dist_in[k*PW +: PW]  = PW'($urandom);
            delta_re[k*DW +: DW] = DW'($urandom);
            delta_im[k*DW +: DW] = DW'($urandom);
        end
        y_re = DW'($urandom); rd_re = DW'($urandom);
        mode = ~mode; keep_delta = ~keep_delta;
    endtask

    task automatic run(bit m, bit kd, bit poke_busy, bit poke_done, string tag);
        int lat;
        logic [Q*PW-1:0] sd;
        logic [Q*IW-1:0] si;
        if (!kd) begin
            for (int k = 0; k < Q; k++) begin st_dre[k] = in_dre[k]; st_dim[k] = in_dim[k]; end
        end
        @(negedge clk);
        pack_ports();
        mode = m; keep_delta = kd; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        if (poke_busy) scramble_ports();
        while (done !== 1'b1 && lat < 50) begin
            start = poke_busy && (lat <= 3);
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        chk("R7", "latency", lat, Q + 2);
        check_lanes(m, poke_busy ? "R8" : tag);
        sd = dist_out; si = idx_out;
        if (poke_done) begin
            start = 1'b1;
            scramble_ports();
        end
        @(negedge clk);
        start = 1'b0;
        chk("R7", "done width", int'(done), 0);
        if (poke_done) begin
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                chk("R8", "no restart from done cycle", int'(done), 0);
            end
            chk("R10", "dist held", int'(dist_out == sd), 1);
            chk("R10", "idx held", int'(idx_out == si), 1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got hang expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; start = 1'b0; mode = 1'b0; keep_delta = 1'b0;
        for (int k = 0; k < Q; k++) begin in_d[k] = 0; in_dre[k] = 0; in_dim[k] = 0; end
        in_yre = 0; in_yim = 0; in_rre = 0; in_rim = 0;
        pack_ports();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "done", int'(done), 0);
        chk("R1", "dist_out", int'(dist_out != '0), 0);
        chk("R1", "idx_out", int'(idx_out != '0), 0);
        rst_n = 1'b1;

        // R5 all costs equal: lowest index wins in both modes
        run(1'b0, 1'b0, 1'b0, 1'b0, "R5");
        run(1'b1, 1'b0, 1'b0, 1'b0, "R5");

        // R4 constellation mapping: y=5+7j, R=1, symbol 3 (1+j) is closest
        in_yre = 5; in_yim = 7; in_rre = 1; in_rim = 0;
        run(1'b1, 1'b0, 1'b0, 1'b0, "R4");
        in_rim = 3;
        run(1'b0, 1'b0, 1'b0, 1'b0, "R4");

        // R6 with R5: clamped ties, one lane with a small distance
        for (int k = 0; k < Q; k++) begin in_d[k] = 65530; in_dre[k] = 0; in_dim[k] = 0; end
        in_d[2] = 100; in_yre = 0; in_yim = 0; in_rre = 300; in_rim = 0;
        run(1'b1, 1'b0, 1'b0, 1'b0, "R6");
        run(1'b0, 1'b0, 1'b0, 1'b0, "R6");

        // R9 interference terms kept from the previous extension
        rand_inputs(3000);
        run(1'b1, 1'b0, 1'b0, 1'b0, "R3");
        rand_inputs(3000);
        run(1'b0, 1'b1, 1'b0, 1'b0, "R9");

        // R8 start while busy, R10 start in the done cycle
        rand_inputs(3000);
        run(1'b0, 1'b0, 1'b1, 1'b0, "R8");
        rand_inputs(3000);
        run(1'b1, 1'b0, 1'b0, 1'b1, "R10");

        // R2 and R3 random mix, some with saturation
        for (int t = 0; t < 40; t++) begin
            rand_inputs((t % 3 == 0) ? MAXD : 3000);
            run(t[0], (t % 5 == 4), (t % 7 == 3), (t % 6 == 2), t[0] ? "R3" : "R2");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule